// File: doc/BRIEF.md
# Complementary Dead-Time Inserter

This block takes a single raw PWM waveform and produces a complementary pair of gate drives: a high-side output and a low-side output. Each edge of the raw waveform starts a 12-bit down counter. Until that counter reaches zero, one of the two output transitions is held back. The result is one of two things, depending on the selected mode. The outputs can be kept apart: both are off for a programmed interval, so the stage breaks before it makes. Or the outputs can be made to overlap: both are on for a programmed interval, so the stage makes before it breaks. A third mode passes the raw waveform and its complement straight through.

Two delay values are supplied. The primary value applies to the interval that follows a rising raw edge. The alternate value applies to the interval that follows a falling raw edge. In break-before-make mode, this means the primary value holds off the high side and the alternate value holds off the low side. In make-before-break mode, the roles reverse: the primary value extends the low side and the alternate value extends the high side. When the center-aligned flag is set, the alternate value governs both edges.

The raw input is registered once, so every output reflects the raw level seen at the previous clock edge. A new raw edge always reloads the counter, and a delay that is still running is abandoned.

Top module: `dtInserter`

## Requirements
- R1: While `rst_n` is low, both outputs are 0. Reset also clears the delay counter. After release, with the raw input low and break-before-make mode selected, the low side is 1 after the first clock edge.
- R2: With `modeSel` = 2'b00 (off) or 2'b11 (unused code), `outHigh` equals the raw input sampled at the previous clock edge and `outLow` is its complement. No delay is added.
- R3: With `modeSel` = 2'b01 (break-before-make), a rising raw edge turns the low side off at once. The high side comes on `dtPrimary` cycles later. The two outputs are never 1 together.
- R4: In break-before-make mode, a falling raw edge turns the high side off at once. The low side comes on `dtAlternate` cycles later.
- R5: With `modeSel` = 2'b10 (make-before-break), a rising raw edge turns the high side on at once. The low side stays on for `dtPrimary` more cycles. The two outputs are never 0 together.
- R6: In make-before-break mode, a falling raw edge turns the low side on at once. The high side stays on for `dtAlternate` more cycles.
- R7: With `centerAligned` = 1, `dtAlternate` sets the delay for both rising and falling edges, and `dtPrimary` is ignored.
- R8: A delay value of 0 adds no delay. The outputs then match the off mode for that edge.
- R9: In break-before-make mode, if a raw high pulse lasts no longer than the high-side delay, the high side stays 0 for that pulse. No shortened pulse appears.
- R10: The counter spans the full `DT_WIDTH` range. A delay of 4095 holds the high side off for exactly 4095 cycles. The counter never counts up except when it is loaded at a raw edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwmIn | input | 1 | Raw PWM waveform |
| modeSel | input | 2 | 00 off, 01 break-before-make, 10 make-before-break, 11 off |
| dtPrimary | input | DT_WIDTH | Delay after a rising raw edge, in cycles |
| dtAlternate | input | DT_WIDTH | Delay after a falling raw edge, in cycles |
| centerAligned | input | 1 | Use `dtAlternate` for both edges |
| outHigh | output | 1 | High-side drive |
| outLow | output | 1 | Low-side drive |

## Verification
The hardest case to reach is a raw edge that arrives while the counter is still running. This happens with a pulse no longer than its delay, and with a reset applied in the middle of a count. The table rows reach it with raw pulses of one and three cycles against delays of one and four, and they count the cycles in which each output is on or off, together with the cycles of overlap and gap. A directed test asserts reset partway through a ten-cycle low-side delay. It then checks that the low side comes on right after release, which is possible only if the count was discarded.

// File: rtl/dtPkg.sv
package dtPkg;

  typedef enum logic [1:0] {
    DT_OFF   = 2'b00,
    DT_BREAK = 2'b01,
    DT_MAKE  = 2'b10,
    DT_SPARE = 2'b11
  } dtMode_t;

  typedef struct packed {
    logic load;
    logic dec;
  } dtStrobe_t;

endpackage

// File: rtl/dtControl.sv
module dtControl
  import dtPkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwmIn,
  input  logic [1:0]    modeSel,
  input  logic [DW-1:0] dtPrimary,
  input  logic [DW-1:0] dtAlternate,
  input  logic          centerAligned,
  input  logic [DW-1:0] cntVal,
  output dtStrobe_t     strobe,
  output logic [DW-1:0] loadValue,
  output logic          outHigh,
  output logic          outLow
);

  logic    pwmQ;
  logic    armed;
  logic    riseSeen;
  logic    fallSeen;
  logic    settled;
  logic    dtActive;
  logic    rawHigh;
  logic    rawLow;
  dtMode_t modeNow;

  assign modeNow = dtMode_t'(modeSel);

  // Registered raw level and a flag that holds the outputs off until the first clock after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwmQ  <= 1'b0;
      armed <= 1'b0;
    end else begin
      pwmQ  <= pwmIn;
      armed <= 1'b1;
    end
  end

  assign riseSeen = pwmIn & ~pwmQ;
  assign fallSeen = ~pwmIn & pwmQ;
  assign settled  = (cntVal == '0);
  assign dtActive = (modeNow == DT_BREAK) || (modeNow == DT_MAKE);

  // The edge type picks the delay. Center alignment forces the alternate value for both edges.
  always_comb begin
    if (!dtActive) begin
      loadValue = '0;
    end else if (centerAligned) begin
      loadValue = dtAlternate;
    end else if (riseSeen) begin
      loadValue = dtPrimary;
    end else begin
      loadValue = dtAlternate;
    end
  end

  always_comb begin
    strobe.load = riseSeen | fallSeen;
    strobe.dec  = ~strobe.load & ~settled;
  end

  // Shape the output pair from the registered level and the counter state.
  always_comb begin
    case (modeNow)
      DT_BREAK: begin
        rawHigh = pwmQ & settled;
        rawLow  = ~pwmQ & settled;
      end
      DT_MAKE: begin
        rawHigh = pwmQ | ~settled;
        rawLow  = ~pwmQ | ~settled;
      end
      default: begin
        rawHigh = pwmQ;
        rawLow  = ~pwmQ;
      end
    endcase
  end

  assign outHigh = armed & rawHigh;
  assign outLow  = armed & rawLow;

endmodule

// File: rtl/dtDatapath.sv
module dtDatapath
  import dtPkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dtStrobe_t     strobe,
  input  logic [DW-1:0] loadValue,
  output logic [DW-1:0] cntVal
);

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntVal <= '0;
    end else if (strobe.load) begin
      cntVal <= loadValue;
    end else if (strobe.dec) begin
      cntVal <= cntVal - ONE;
    end
  end

endmodule

// File: rtl/dtInserter.sv
module dtInserter
  import dtPkg::*;
#(
  parameter int DT_WIDTH = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwmIn,
  input  logic [1:0]          modeSel,
  input  logic [DT_WIDTH-1:0] dtPrimary,
  input  logic [DT_WIDTH-1:0] dtAlternate,
  input  logic                centerAligned,
  output logic                outHigh,
  output logic                outLow
);

  dtStrobe_t           strobe;
  logic [DT_WIDTH-1:0] loadValue;
  logic [DT_WIDTH-1:0] cntVal;

  dtControl #(.DW(DT_WIDTH)) ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .pwmIn(pwmIn),
    .modeSel(modeSel),
    .dtPrimary(dtPrimary),
    .dtAlternate(dtAlternate),
    .centerAligned(centerAligned),
    .cntVal(cntVal),
    .strobe(strobe),
    .loadValue(loadValue),
    .outHigh(outHigh),
    .outLow(outLow)
  );

  dtDatapath #(.DW(DT_WIDTH)) dpath (
    .clk(clk),
    .rst_n(rst_n),
    .strobe(strobe),
    .loadValue(loadValue),
    .cntVal(cntVal)
  );

endmodule

// File: rtl/dtInserterChecker.sv
module dtInserterChecker
  import dtPkg::*;
#(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    modeSel,
  input logic          outHigh,
  input logic          outLow,
  input dtStrobe_t     strobe,
  input logic [DW-1:0] cntVal
);

  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  AST_BREAK_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (live && modeSel == 2'b01) |-> !(outHigh && outLow)); // R3

  AST_MAKE_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (live && modeSel == 2'b10) |-> (outHigh || outLow)); // R5

  AST_OFF_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (modeSel == 2'b00 || modeSel == 2'b11)) |-> (outHigh != outLow)); // R2

  AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> (cntVal <= $past(cntVal))); // R10

endmodule

bind dtInserter dtInserterChecker #(.DW(DT_WIDTH)) chk (
  .clk(clk),
  .rst_n(rst_n),
  .modeSel(modeSel),
  .outHigh(outHigh),
  .outLow(outLow),
  .strobe(strobe),
  .cntVal(cntVal)
);

// File: tb/dtInserter_test.sv
module dtInserter_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int ROWS = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [11:0] prim;
    logic [11:0] alt;
    logic        center;
    logic [15:0] width;
    logic [15:0] expHighOn;
    logic [15:0] expLowOff;
    logic [15:0] expOverlap;
    logic [15:0] expGap;
  } row_t;

  localparam row_t TABLE [ROWS] = '{
    '{2'b01, 12'd3, 12'd5, 1'b0, 16'd10, 16'd7,  16'd15, 16'd0, 16'd8},
    '{2'b01, 12'd4, 12'd2, 1'b0, 16'd3,  16'd0,  16'd5,  16'd0, 16'd5},
    '{2'b10, 12'd3, 12'd5, 1'b0, 16'd10, 16'd15, 16'd7,  16'd8, 16'd0},
    '{2'b10, 12'd6, 12'd2, 1'b0, 16'd4,  16'd6,  16'd0,  16'd6, 16'd0},
    '{2'b00, 12'd3, 12'd5, 1'b0, 16'd10, 16'd10, 16'd10, 16'd0, 16'd0},
    '{2'b01, 12'd0, 12'd0, 1'b0, 16'd6,  16'd6,  16'd6,  16'd0, 16'd0},
    '{2'b01, 12'd9, 12'd3, 1'b1, 16'd10, 16'd7,  16'd13, 16'd0, 16'd6},
    '{2'b10, 12'd9, 12'd2, 1'b1, 16'd8,  16'd10, 16'd6,  16'd4, 16'd0},
    '{2'b11, 12'd3, 12'd5, 1'b0, 16'd5,  16'd5,  16'd5,  16'd0, 16'd0},
    '{2'b01, 12'd1, 12'd1, 1'b0, 16'd1,  16'd0,  16'd2,  16'd0, 16'd2}
  };

  localparam string ROW_TAG [ROWS] = '{
    "R3 R4", "R9", "R5 R6", "R5 R6", "R2",
    "R8", "R7", "R7", "R2", "R9"
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwmIn = 1'b0;
  logic [1:0]    modeSel = 2'b01;
  logic [DW-1:0] dtPrimary = '0;
  logic [DW-1:0] dtAlternate = '0;
  logic          centerAligned = 1'b0;
  logic          outHigh;
  logic          outLow;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  dtInserter #(.DT_WIDTH(DW)) uut (
    .clk(clk),
    .rst_n(rst_n),
    .pwmIn(pwmIn),
    .modeSel(modeSel),
    .dtPrimary(dtPrimary),
    .dtAlternate(dtAlternate),
    .centerAligned(centerAligned),
    .outHigh(outHigh),
    .outLow(outLow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    pwmIn = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic runPulse(input int w, output int hOn, output int lOff,
                          output int ov, output int gp);
    hOn = 0; lOff = 0; ov = 0; gp = 0;
    pwmIn = 1'b1;
    for (int k = 1; k <= w + 20; k++) begin
      @(negedge clk);
      if (outHigh) hOn++;
      if (!outLow) lOff++;
      if (outHigh && outLow) ov++;
      if (!outHigh && !outLow) gp++;
      pwmIn = (k < w);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int hOn, lOff, ov, gp;

    // R1: outputs idle while reset is held
    repeat (2) @(negedge clk);
    check("R1", "outHigh in reset", int'(outHigh), 0);
    check("R1", "outLow in reset", int'(outLow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outLow after release", int'(outLow), 1);
    check("R1", "outHigh after release", int'(outHigh), 0);

    // Table walk
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      modeSel = TABLE[r].mode;
      dtPrimary = TABLE[r].prim;
      dtAlternate = TABLE[r].alt;
      centerAligned = TABLE[r].center;
      settle();
      runPulse(int'(TABLE[r].width), hOn, lOff, ov, gp);
      check(ROW_TAG[r], $sformatf("row %0d high-on cycles", r), hOn, int'(TABLE[r].expHighOn));
      check(ROW_TAG[r], $sformatf("row %0d low-off cycles", r), lOff, int'(TABLE[r].expLowOff));
      check(ROW_TAG[r], $sformatf("row %0d overlap cycles", r), ov, int'(TABLE[r].expOverlap));
      check(ROW_TAG[r], $sformatf("row %0d gap cycles", r), gp, int'(TABLE[r].expGap));
    end

    // R3: exact rise timing with a delay of 2
    @(negedge clk);
    modeSel = 2'b01; dtPrimary = 12'd2; dtAlternate = 12'd0; centerAligned = 1'b0;
    settle();
    pwmIn = 1'b1;
    @(negedge clk);
    check("R3", "high after edge+0", int'(outHigh), 0);
    check("R3", "low after edge+0", int'(outLow), 0);
    @(negedge clk);
    check("R3", "high after edge+1", int'(outHigh), 0);
    @(negedge clk);
    check("R3", "high after edge+2", int'(outHigh), 1);
    pwmIn = 1'b0;

    // R10: full-range delay
    @(negedge clk);
    modeSel = 2'b01; dtPrimary = 12'd4095; dtAlternate = 12'd0; centerAligned = 1'b0;
    settle();
    runPulse(4100, hOn, lOff, ov, gp);
    check("R10", "high-on with delay 4095", hOn, 5);
    check("R10", "gap with delay 4095", gp, 4095);

    // R1: reset in the middle of a low-side delay clears the count
    @(negedge clk);
    modeSel = 2'b01; dtPrimary = 12'd0; dtAlternate = 12'd10; centerAligned = 1'b0;
    settle();
    pwmIn = 1'b1;
    repeat (3) @(negedge clk);
    pwmIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R4", "low held during delay", int'(outLow), 0);
    rst_n = 1'b0;
    #1;
    check("R1", "outHigh during mid-count reset", int'(outHigh), 0);
    check("R1", "outLow during mid-count reset", int'(outLow), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outLow right after release", int'(outLow), 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule